// File: doc/BRIEF.md
# Ring Control Register Block with Reset/Ready Handshake

This block holds the configuration a host driver writes for a transmit ring and a receive ring: the base address of each ring, the byte size of each ring, the host-side cursor of each ring, and the host memory address of a cursor status record. The values reach the ring engines as plain configuration outputs. The host cannot read any of them back. The only readable location is a ready flag. The host polls this flag after power-up and after each transmit/receive reset it requests.

The block does not let the host read the device cursors through registers. Instead it pushes a 16-byte record into host memory through a simple valid/ready write port. The record holds the current device transmit cursor and the current device receive cursor. A new record is written whenever either cursor has moved since the last record and no record is in flight.

A transmit/receive reset is started by writing exactly 1 to the reset location. The block then drops the ready flag and holds the ring engines in reset for a fixed number of cycles. After that it raises ready and owes the host a fresh record.

Top module: `ring_ctl_regs`

## Requirements
- R1: A host write to word index 0 (tx base), 1 (rx base), 2 (tx size), 3 (rx size), 4 (tx host cursor), 5 (rx host cursor) or 6 (status record address) updates the matching configuration output on the next clock edge.
- R2: A host read returns its data one cycle after the read strobe. Index 8 returns the ready flag in bit 0 with all other bits zero. Every other index reads as zero.
- R3: Writing the value 1 (all 64 bits) to index 7 drops ready and holds `eng_rst_n` low for exactly 16 cycles, after which ready reads 1. Power-up runs the same 16-cycle hold with ready at 0.
- R4: Writing any value other than 1 to index 7 leaves ready and `eng_rst_n` unchanged.
- R5: A status record is two beats on the write port. The first beat carries the transmit cursor at the record address with `sw_last` low. The second beat carries the receive cursor at the record address plus 8 with `sw_last` high.
- R6: A record starts when no record is in flight and either device cursor differs from the values carried by the previous record. The cursors are captured when the record starts; later changes go into a following record.
- R7: No record starts while ready is 0 or while the status record address is zero.
- R8: After each reset hold ends, one record is written even if the cursors equal those of the last record.
- R9: While `sw_valid` is high and `sw_ready` is low, the beat's address, data and `sw_last` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_wr_en | input | 1 | Host register write strobe |
| hb_rd_en | input | 1 | Host register read strobe |
| hb_idx | input | 4 | Register word index |
| hb_wdata | input | 64 | Host write data |
| hb_rdata | output | 64 | Host read data, valid one cycle after the read strobe |
| tx_base | output | 64 | Transmit ring base address |
| rx_base | output | 64 | Receive ring base address |
| tx_len | output | 32 | Transmit ring size in bytes |
| rx_len | output | 32 | Receive ring size in bytes |
| tx_host_cur | output | 64 | Host transmit cursor |
| rx_host_cur | output | 64 | Host receive cursor |
| eng_rst_n | output | 1 | Active-low reset to the ring engines |
| dev_tx_cur | input | 64 | Device transmit cursor from the engine |
| dev_rx_cur | input | 64 | Device receive cursor from the engine |
| sw_valid | output | 1 | Status beat valid |
| sw_ready | input | 1 | Status beat accepted |
| sw_addr | output | 64 | Host byte address of the beat |
| sw_data | output | 64 | Beat data (a cursor) |
| sw_last | output | 1 | High on the second beat of a record |

## Verification
The record writer is tested under several cursor patterns:
- Cursors that move while the record address is zero must produce no traffic.
- Setting a non-zero address alone must release a record.
- Moving only one cursor must still produce a full two-beat record.
- Holding the cursors still must produce nothing.
- Moving a cursor while a record is stalled by backpressure must give two records with different snapshots. This shows that the cursors are captured when a record starts and not when it is accepted.

Resets are tested with:
- Values other than 1, including one whose low bit alone is 1, to show that the reset location decodes the full word.
- A real reset in which the cursors are parked at values equal to the last record. A record that still follows can only come from the post-reset obligation.

// File: rtl/ring_ctl_pkg.sv
// Package: shared widths, register indices and record-writer states for the
// ring control block. Assumes a 64-bit host data path.
package ring_ctl_pkg;
    localparam int unsigned WORD_W = 64;
    localparam int unsigned IDX_W  = 4;

    typedef enum logic [IDX_W-1:0] {
        RI_TX_BASE = 4'd0,
        RI_RX_BASE = 4'd1,
        RI_TX_LEN  = 4'd2,
        RI_RX_LEN  = 4'd3,
        RI_TX_HCUR = 4'd4,
        RI_RX_HCUR = 4'd5,
        RI_STATADR = 4'd6,
        RI_RESET   = 4'd7,
        RI_READY   = 4'd8
    } reg_idx_e;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_TX   = 2'd1,
        SW_RX   = 2'd2
    } sw_state_e;
endpackage

// File: rtl/ring_ctl_regfile.sv
// Module: ring_ctl_regfile
// Decodes host register writes into configuration registers and returns the
// ready flag on reads. Assumes one access per cycle; a read returns data on
// the following cycle. Emits a one-cycle reset request only for the exact
// value 1 written to the reset index.
module ring_ctl_regfile
    import ring_ctl_pkg::*;
#(
    parameter int unsigned LEN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ready,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] tx_base,
    output logic [WORD_W-1:0] rx_base,
    output logic [LEN_W-1:0]  tx_len,
    output logic [LEN_W-1:0]  rx_len,
    output logic [WORD_W-1:0] tx_hcur,
    output logic [WORD_W-1:0] rx_hcur,
    output logic [WORD_W-1:0] stat_addr,
    output logic              rst_req
);
    localparam logic [WORD_W-1:0] RESET_KEY = WORD_W'(1);

    // Reset request: only a full-word match of the key starts a reset.
    assign rst_req = wr_en && (idx == RI_RESET) && (wdata == RESET_KEY);

    // Configuration registers: capture host writes by index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_base   <= '0;
            rx_base   <= '0;
            tx_len    <= '0;
            rx_len    <= '0;
            tx_hcur   <= '0;
            rx_hcur   <= '0;
            stat_addr <= '0;
        end else if (wr_en) begin
            case (idx)
                RI_TX_BASE: tx_base   <= wdata;
                RI_RX_BASE: rx_base   <= wdata;
                RI_TX_LEN:  tx_len    <= wdata[LEN_W-1:0];
                RI_RX_LEN:  rx_len    <= wdata[LEN_W-1:0];
                RI_TX_HCUR: tx_hcur   <= wdata;
                RI_RX_HCUR: rx_hcur   <= wdata;
                RI_STATADR: stat_addr <= wdata;
                default: ;
            endcase
        end
    end

    // Read port: only the ready flag is visible, everything else reads zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= (idx == RI_READY) ? {{(WORD_W-1){1'b0}}, ready} : '0;
        end
    end
endmodule

// File: rtl/ring_ctl_rst_seq.sv
// Module: ring_ctl_rst_seq
// Sequences the transmit/receive reset. It holds the ring engines in reset for
// HOLD_CYC cycles after power-up or after a host request, then raises ready.
// A request during the hold restarts the count.
module ring_ctl_rst_seq #(
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    output logic busy,
    output logic ready
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Hold counter and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b1;
            cnt   <= '0;
            ready <= 1'b0;
        end else if (rst_req) begin
            busy  <= 1'b1;
            cnt   <= '0;
            ready <= 1'b0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy  <= 1'b0;
                ready <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ring_ctl_status_wr.sv
// Module: ring_ctl_status_wr
// Pushes the two device cursors to host memory as a two-beat record whenever
// they move, after a reset hold, and only while ready with a non-zero address.
// Assumes the write port keeps valid/ready semantics: a beat is held until
// accepted.
module ring_ctl_status_wr
    import ring_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ready,
    input  logic [WORD_W-1:0] stat_addr,
    input  logic [WORD_W-1:0] cur_tx,
    input  logic [WORD_W-1:0] cur_rx,
    output logic              sw_valid,
    input  logic              sw_ready,
    output logic [WORD_W-1:0] sw_addr,
    output logic [WORD_W-1:0] sw_data,
    output logic              sw_last
);
    localparam logic [WORD_W-1:0] BEAT_BYTES = WORD_W'(WORD_W / 8);

    sw_state_e         st;
    logic              owed;
    logic [WORD_W-1:0] last_tx, last_rx, snap_tx, snap_rx, base;
    logic              start;

    // Start condition: idle, enabled and something new to report.
    assign start = (st == SW_IDLE) && ready && (stat_addr != '0) &&
                   (owed || (cur_tx != last_tx) || (cur_rx != last_rx));

    // Record state machine with snapshot capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SW_IDLE;
            owed    <= 1'b0;
            last_tx <= '0;
            last_rx <= '0;
            snap_tx <= '0;
            snap_rx <= '0;
            base    <= '0;
        end else begin
            if (clear) begin
                owed    <= 1'b1;
                last_tx <= '0;
                last_rx <= '0;
            end
            case (st)
                SW_IDLE: if (start) begin
                    snap_tx <= cur_tx;
                    snap_rx <= cur_rx;
                    last_tx <= cur_tx;
                    last_rx <= cur_rx;
                    base    <= stat_addr;
                    owed    <= 1'b0;
                    st      <= SW_TX;
                end
                SW_TX:   if (sw_ready) st <= SW_RX;
                SW_RX:   if (sw_ready) st <= SW_IDLE;
                default: st <= SW_IDLE;
            endcase
        end
    end

    // Beat outputs derived from the current state.
    assign sw_valid = (st != SW_IDLE);
    assign sw_last  = (st == SW_RX);
    assign sw_addr  = sw_last ? base + BEAT_BYTES : base;
    assign sw_data  = sw_last ? snap_rx : snap_tx;
endmodule

// File: rtl/ring_ctl_regs.sv
// Module: ring_ctl_regs (top)
// Ring control registers with reset/ready handshake and pushed cursor record.
// Wires the register file, the reset sequencer and the record writer. Assumes
// the ring engines clear their cursors while eng_rst_n is low.
module ring_ctl_regs
    import ring_ctl_pkg::*;
#(
    parameter int unsigned LEN_W    = 32,
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_wr_en,
    input  logic              hb_rd_en,
    input  logic [3:0]        hb_idx,
    input  logic [63:0]       hb_wdata,
    output logic [63:0]       hb_rdata,
    output logic [63:0]       tx_base,
    output logic [63:0]       rx_base,
    output logic [LEN_W-1:0]  tx_len,
    output logic [LEN_W-1:0]  rx_len,
    output logic [63:0]       tx_host_cur,
    output logic [63:0]       rx_host_cur,
    output logic              eng_rst_n,
    input  logic [63:0]       dev_tx_cur,
    input  logic [63:0]       dev_rx_cur,
    output logic              sw_valid,
    input  logic              sw_ready,
    output logic [63:0]       sw_addr,
    output logic [63:0]       sw_data,
    output logic              sw_last
);
    logic              rst_req;
    logic              busy;
    logic              ready;
    logic [WORD_W-1:0] stat_addr;

    ring_ctl_regfile #(.LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(hb_wr_en), .rd_en(hb_rd_en),
        .idx(hb_idx), .wdata(hb_wdata), .ready(ready), .rdata(hb_rdata),
        .tx_base(tx_base), .rx_base(rx_base), .tx_len(tx_len), .rx_len(rx_len),
        .tx_hcur(tx_host_cur), .rx_hcur(rx_host_cur), .stat_addr(stat_addr),
        .rst_req(rst_req)
    );

    ring_ctl_rst_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .busy(busy), .ready(ready)
    );

    // Engines stay in reset for as long as the sequencer is holding.
    assign eng_rst_n = !busy;

    ring_ctl_status_wr u_stat (
        .clk(clk), .rst_n(rst_n), .clear(busy), .ready(ready),
        .stat_addr(stat_addr), .cur_tx(dev_tx_cur), .cur_rx(dev_rx_cur),
        .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_addr(sw_addr),
        .sw_data(sw_data), .sw_last(sw_last)
    );
endmodule

// File: rtl/ring_ctl_regs_chk.sv
// Module: ring_ctl_regs_chk
// Property checker for ring_ctl_regs, attached by bind. Observes the reset
// handshake and the record write port.
module ring_ctl_regs_chk #(
    parameter int unsigned HOLD_CYC = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hb_wr_en,
    input logic [3:0]  hb_idx,
    input logic [63:0] hb_wdata,
    input logic        rst_req,
    input logic        ready,
    input logic        eng_rst_n,
    input logic [63:0] stat_addr,
    input logic        sw_valid,
    input logic        sw_ready,
    input logic [63:0] sw_addr,
    input logic [63:0] sw_data,
    input logic        sw_last
);
    logic [7:0] low_cnt;

    // Counts consecutive cycles with the engines held in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_cnt <= '0;
        else if (rst_req)    low_cnt <= '0;
        else if (!eng_rst_n) low_cnt <= low_cnt + 1'b1;
        else                 low_cnt <= '0;
    end

    assert_hold_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_rst_n) |-> (low_cnt == 8'(HOLD_CYC)));

    assert_req_drops_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (!ready && !eng_rst_n));

    assert_other_value_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_wr_en && hb_idx == 4'd7 && hb_wdata != 64'd1 && ready) |=> ready);

    assert_start_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_valid) |-> ($past(ready) && $past(stat_addr) != 64'd0));

    assert_beat_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && !sw_ready) |=>
            (sw_valid && $stable(sw_addr) && $stable(sw_data) && $stable(sw_last)));

    assert_second_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_ready && !sw_last) |=>
            (sw_valid && sw_last && sw_addr == $past(sw_addr) + 64'd8));

    assert_record_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_ready && sw_last) |=> !sw_valid);
endmodule

bind ring_ctl_regs ring_ctl_regs_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .hb_wr_en(hb_wr_en), .hb_idx(hb_idx),
    .hb_wdata(hb_wdata), .rst_req(rst_req), .ready(ready),
    .eng_rst_n(eng_rst_n), .stat_addr(stat_addr), .sw_valid(sw_valid),
    .sw_ready(sw_ready), .sw_addr(sw_addr), .sw_data(sw_data),
    .sw_last(sw_last)
);

// File: tb/ring_ctl_regs_tb.sv
`timescale 1ns/1ps
module ring_ctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hb_wr_en = 1'b0, hb_rd_en = 1'b0;
    logic [3:0]  hb_idx = '0;
    logic [63:0] hb_wdata = '0, hb_rdata;
    logic [63:0] tx_base, rx_base, tx_host_cur, rx_host_cur;
    logic [31:0] tx_len, rx_len;
    logic        eng_rst_n;
    logic [63:0] dev_tx_cur = '0, dev_rx_cur = '0;
    logic        sw_valid, sw_last, sw_ready = 1'b1;
    logic [63:0] sw_addr, sw_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ring_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .hb_wr_en(hb_wr_en), .hb_rd_en(hb_rd_en),
        .hb_idx(hb_idx), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .tx_base(tx_base), .rx_base(rx_base), .tx_len(tx_len), .rx_len(rx_len),
        .tx_host_cur(tx_host_cur), .rx_host_cur(rx_host_cur),
        .eng_rst_n(eng_rst_n), .dev_tx_cur(dev_tx_cur), .dev_rx_cur(dev_rx_cur),
        .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_addr(sw_addr),
        .sw_data(sw_data), .sw_last(sw_last)
    );

    // Captured accepted beats.
    logic [63:0] cap_addr [32];
    logic [63:0] cap_data [32];
    logic        cap_last [32];
    int          ncap = 0;

    always @(posedge clk) begin
        if (rst_n && sw_valid && sw_ready && ncap < 32) begin
            cap_addr[ncap] <= sw_addr;
            cap_data[ncap] <= sw_data;
            cap_last[ncap] <= sw_last;
            ncap <= ncap + 1;
        end
    end

    // Configuration write vectors: index and data, then expected output.
    localparam logic [3:0]  VI [7] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6};
    localparam logic [63:0] VD [7] = '{64'h0000_00AB_CDEF_0000, 64'h0000_0012_3456_7000,
                                       64'h0000_0000_0000_4000, 64'h0000_0000_0001_0000,
                                       64'h0000_0000_0000_0123, 64'h0000_0000_0000_0456,
                                       64'h0000_0000_0000_0000};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] i, input logic [63:0] d);
        hb_wr_en = 1'b1; hb_idx = i; hb_wdata = d;
        @(posedge clk);
        @(negedge clk);
        hb_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] i, output logic [63:0] d);
        hb_rd_en = 1'b1; hb_idx = i;
        @(posedge clk);
        @(negedge clk);
        hb_rd_en = 1'b0;
        d = hb_rdata;
    endtask

    // Counts cycles (sampled at negedges) with engines held in reset.
    task automatic measure_hold(output int n);
        n = 0;
        while (!eng_rst_n && n < 40) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [63:0] cfg_out(input logic [3:0] i);
        case (i)
            4'd0: return tx_base;
            4'd1: return rx_base;
            4'd2: return {32'd0, tx_len};
            4'd3: return {32'd0, rx_len};
            4'd4: return tx_host_cur;
            4'd5: return rx_host_cur;
            4'd6: return u_dut.stat_addr;
            default: return '0;
        endcase
    endfunction

    task automatic expect_rec(input int at, input logic [63:0] a, input logic [63:0] t,
                              input logic [63:0] r, input string req);
        chk({req, " record present"}, 64'(ncap >= at + 2), 64'd1);
        if (ncap >= at + 2) begin
            chk({req, " R5 tx beat addr"}, cap_addr[at], a);
            chk({req, " R5 tx beat data"}, cap_data[at], t);
            chk({req, " R5 tx beat last"}, 64'(cap_last[at]), 64'd0);
            chk({req, " R5 rx beat addr"}, cap_addr[at+1], a + 64'd8);
            chk({req, " R5 rx beat data"}, cap_data[at+1], r);
            chk({req, " R5 rx beat last"}, 64'(cap_last[at+1]), 64'd1);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] d;
        int n, base_n;
        tick(3);
        // Reset state.
        chk("R3 reset engines held", 64'(eng_rst_n), 64'd0);
        chk("R7 no record in reset", 64'(sw_valid), 64'd0);
        rst_n = 1'b1;
        measure_hold(n);
        chk("R3 power-up hold length", 64'(n), 64'd16);
        rd(4'd8, d);
        chk("R3 ready after power-up", d, 64'd1);

        // Vector table of configuration writes (R1); status addr kept zero here.
        for (int k = 0; k < 7; k++) begin
            wr(VI[k], VD[k]);
            chk("R1 config write", cfg_out(VI[k]), VD[k]);
        end
        rd(4'd0, d);
        chk("R2 write-only reads zero", d, 64'd0);
        rd(4'd7, d);
        chk("R2 reset index reads zero", d, 64'd0);

        // R7: cursors move while the record address is zero.
        base_n = ncap;
        dev_tx_cur = 64'h10; dev_rx_cur = 64'h20;
        tick(10);
        chk("R7 no record with zero address", 64'(ncap), 64'(base_n));

        // R6/R8: non-zero address releases the owed record.
        wr(4'd6, 64'h1000);
        tick(10);
        expect_rec(base_n, 64'h1000, 64'h10, 64'h20, "R6 first");
        base_n = ncap;

        // R6: one cursor moves.
        dev_tx_cur = 64'h30;
        tick(10);
        expect_rec(base_n, 64'h1000, 64'h30, 64'h20, "R6 tx move");
        base_n = ncap;

        // R6: no movement, no record.
        tick(10);
        chk("R6 idle no record", 64'(ncap), 64'(base_n));

        // R9/R6: backpressure with a cursor moving while stalled.
        sw_ready = 1'b0;
        dev_rx_cur = 64'h44;
        tick(5);
        chk("R9 stalled valid", 64'(sw_valid), 64'd1);
        chk("R9 stalled data", sw_data, 64'h30);
        dev_tx_cur = 64'h50;
        tick(3);
        chk("R9 data held", sw_data, 64'h30);
        chk("R9 addr held", sw_addr, 64'h1000);
        sw_ready = 1'b1;
        tick(12);
        expect_rec(base_n, 64'h1000, 64'h30, 64'h44, "R6 snapshot");
        expect_rec(base_n + 2, 64'h1000, 64'h50, 64'h44, "R6 follow-up");

        // R4: non-key values at the reset index.
        wr(4'd7, 64'd2);
        chk("R4 value 2 keeps engines", 64'(eng_rst_n), 64'd1);
        wr(4'd7, 64'h1_0000_0001);
        chk("R4 high-bit value keeps engines", 64'(eng_rst_n), 64'd1);
        rd(4'd8, d);
        chk("R4 ready unchanged", d, 64'd1);

        // R3: real reset; engines clear cursors during the hold.
        wr(4'd7, 64'd1);
        dev_tx_cur = '0; dev_rx_cur = '0;
        measure_hold(n);
        chk("R3 host reset hold length", 64'(n), 64'd16);
        tick(10);
        base_n = ncap - 2;
        expect_rec(base_n, 64'h1000, 64'h0, 64'h0, "R8 after reset");

        // R3/R7/R8: ready reads 0 in the hold; no record while not ready.
        base_n = ncap;
        wr(4'd7, 64'd1);
        rd(4'd8, d);
        chk("R3 ready low during hold", d, 64'd0);
        dev_tx_cur = 64'h55;
        tick(6);
        chk("R7 no record while not ready", 64'(ncap), 64'(base_n));
        dev_tx_cur = '0;
        while (!eng_rst_n) @(negedge clk);
        chk("R7 nothing before ready", 64'(ncap), 64'(base_n));
        tick(10);
        expect_rec(base_n, 64'h1000, 64'h0, 64'h0, "R8 owed record");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule